// File: doc/BRIEF.md
# Trap Entry and Control Register Legalizer

This block keeps the trap-related control registers of a single hardware thread: the return addresses for machine, supervisor and debug entry, the two trap base registers, the cause and trap-value pairs, the extension-capability word, the address-translation root register, and a small status word. It legalizes every software write so that each register only ever holds a value the hart can use. Trap entry also goes through this block. It updates the registers for the trap target level and produces the new program counter.

Software reaches the registers through a register port. The port carries a 12-bit address, write data and a write enable, and returns the read data combinationally. A trap request carries a cause, the faulting pc, a trap value and a flag that selects supervisor instead of machine handling. In the clock edge where the request is presented, the block moves the privilege level, saves the interrupt-enable state and loads the handler address into `nextPc`. A write to the translation root register sends a one-cycle pulse to the translation cache so that it drops its entries.

Top module: `trap_csr_unit`

## Requirements
- R1: After reset the privilege is machine (code 3) and `nextPc` equals the reset vector. The capability word (address 0x301) equals its reset capability value, and every other register reads zero.
- R2: A write to the machine return address (0x341), the supervisor return address (0x141) or the debug return address (0x7B1) stores the data with bit 0 forced to zero.
- R3: A write to the supervisor trap base (0x105) clears bits 1:0. A write to the machine trap base (0x305) clears only bit 1 and keeps bit 0, the vectored-mode flag.
- R4: A trap with the supervisor flag set does the following: it loads `nextPc` from the supervisor trap base, stores the cause (0x142), stores the pc with bit 0 cleared (0x141) and stores the trap value (0x143). In the status word (0x300) it copies bit 1 into bit 5, clears bit 1, and sets bit 8 when the prior privilege was not user. The privilege becomes supervisor (code 1).
- R5: A trap without the supervisor flag loads `nextPc` with the machine trap base with bit 0 cleared, plus an offset. The offset is 4 times the cause when the cause has bit 63 set (interrupt) and the base has bit 0 set, and zero otherwise. The trap stores the pc with bit 0 cleared (0x341), the cause (0x342) and the value (0x343). It copies status bit 3 into bit 7, clears bit 3 and writes the prior privilege into bits 12:11. The privilege becomes machine.
- R6: In the capability word, only the letter bits A(0), C(2), D(3), F(5) and M(12) that the reset value also has can change. All other bits keep their value. A write with bit 5 clear also clears bit 3.
- R7: A write to the translation root (0x180) is accepted only when bits 63:60 are 0, 8 or 9. An accepted write keeps bits 63:60 and 43:0 and zeroes bits 59:44. A write with any other mode leaves the register unchanged.
- R8: Every write to the translation root, accepted or not, raises `tlbFlush` for exactly the one cycle after the write edge.
- R9: When `narrowMode` is high, a read of the supervisor cause copies bit 63 into bit 31.
- R10: An address outside the implemented set reads zero and raises `csrIllegal`. A write to such an address changes no register.
- R11: When a trap and a register write arrive in the same cycle, the trap is taken and the write is dropped. This includes the flush pulse.
- R12: Only status bits 1, 3, 5, 7, 8 and 12:11 are writable. All other status bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| csrAddr | input | 12 | Register address for read and write |
| csrWdata | input | 64 | Write data |
| csrWe | input | 1 | Write enable |
| csrRdata | output | 64 | Read data for `csrAddr` (combinational) |
| csrIllegal | output | 1 | `csrAddr` is not an implemented register |
| narrowMode | input | 1 | Current register width is 32 bits |
| trapValid | input | 1 | Take a trap this cycle |
| trapToSuper | input | 1 | Handle the trap at supervisor level |
| trapCause | input | 64 | Cause, bit 63 marks an interrupt |
| trapEpc | input | 64 | pc of the trapping instruction |
| trapTval | input | 64 | Trap value |
| nextPc | output | 64 | Program counter after reset or the latest trap |
| privMode | output | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| tlbFlush | output | 1 | One-cycle translation cache flush pulse |

## Verification
A software write and a trap entry can land in the same cycle. The two can target the same register, or the write can be one with a side effect. The bench provokes both cases. In one, it writes the machine return address while a machine trap saves a different pc. In the other, it writes the translation root together with a trap. It then judges that the saved pc is the trap's own, that the translation root keeps its old value and that no flush pulse appears.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MSTATUS, SEL_MISA, SEL_MTVEC, SEL_MEPC, SEL_MCAUSE, SEL_MTVAL,
    SEL_STVEC, SEL_SEPC, SEL_SCAUSE, SEL_STVAL, SEL_SATP, SEL_DPC
  } csrSel_e;

  typedef struct packed {
    logic    wrEn;
    csrSel_e sel;
    logic    trapM;
    logic    trapS;
  } ctrlStrobes_t;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  // status word bit positions
  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;

  // capability letters that software may toggle: A, C, D, F, M
  localparam logic [63:0] MISA_LETTER_WR = 64'h0000_0000_0000_102D;
  localparam int          MISA_F = 5;
  localparam int          MISA_D = 3;

  function automatic csrSel_e decodeAddr(input logic [11:0] addr);
    case (addr)
      12'h300: decodeAddr = SEL_MSTATUS;
      12'h301: decodeAddr = SEL_MISA;
      12'h305: decodeAddr = SEL_MTVEC;
      12'h341: decodeAddr = SEL_MEPC;
      12'h342: decodeAddr = SEL_MCAUSE;
      12'h343: decodeAddr = SEL_MTVAL;
      12'h105: decodeAddr = SEL_STVEC;
      12'h141: decodeAddr = SEL_SEPC;
      12'h142: decodeAddr = SEL_SCAUSE;
      12'h143: decodeAddr = SEL_STVAL;
      12'h180: decodeAddr = SEL_SATP;
      12'h7B1: decodeAddr = SEL_DPC;
      default: decodeAddr = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/trap_csr_ctrl.sv
module trap_csr_ctrl
  import trap_csr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [11:0]  csrAddr,
  input  logic         csrWe,
  input  logic         trapValid,
  input  logic         trapToSuper,
  output ctrlStrobes_t strobes,
  output logic         csrIllegal
);

  csrSel_e selD;

  always_comb begin
    selD          = decodeAddr(csrAddr);
    strobes.sel   = selD;
    strobes.trapS = trapValid && trapToSuper;
    strobes.trapM = trapValid && !trapToSuper;
    // a trap in the same cycle drops the software write
    strobes.wrEn  = csrWe && !trapValid && (selD != SEL_NONE);
    csrIllegal    = (selD == SEL_NONE);
  end

  assert_trap_drops_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && csrWe) |-> !strobes.wrEn);

  assert_one_trap_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.trapM, strobes.trapS}));

  assert_unimpl_no_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    csrIllegal |-> !strobes.wrEn);

endmodule

// File: rtl/trap_csr_dpath.sv
module trap_csr_dpath
  import trap_csr_pkg::*;
#(
  parameter int          XLEN      = 64,
  parameter int          NARROW    = 32,
  parameter logic [63:0] RESET_VEC = 64'h0000_0000_8000_0000,
  parameter logic [63:0] MISA_CAP  = 64'h8000_0000_0014_112D
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [XLEN-1:0]  csrWdata,
  input  logic             narrowMode,
  input  logic [XLEN-1:0]  trapCause,
  input  logic [XLEN-1:0]  trapEpc,
  input  logic [XLEN-1:0]  trapTval,
  output logic [XLEN-1:0]  csrRdata,
  output logic [XLEN-1:0]  nextPc,
  output logic [1:0]       privMode,
  output logic             tlbFlush
);

  localparam logic [XLEN-1:0] ST_WMASK   = XLEN'(64'h19AA);
  localparam logic [XLEN-1:0] MISA_WMASK = XLEN'(MISA_CAP & MISA_LETTER_WR);
  localparam logic [XLEN-1:0] SATP_KEEP  = XLEN'(64'hF000_0FFF_FFFF_FFFF);
  localparam logic [XLEN-1:0] EVEN_MASK  = ~XLEN'(1);

  logic [XLEN-1:0] mstatusQ, misaQ, mtvecQ, mepcQ, mcauseQ, mtvalQ;
  logic [XLEN-1:0] stvecQ, sepcQ, scauseQ, stvalQ, satpQ, dpcQ, pcQ;
  logic [1:0]      privQ;
  logic            flushQ;

  logic [XLEN-1:0] misaNew, vecOff, scauseRd;
  logic            satpLegal, wr;

  assign wr = strobes.wrEn;

  always_comb begin
    misaNew = csrWdata;
    if (!csrWdata[MISA_F]) misaNew[MISA_D] = 1'b0;
    vecOff = '0;
    if (mtvecQ[0] && trapCause[XLEN-1]) vecOff = {trapCause[XLEN-3:0], 2'b00};
    satpLegal = (csrWdata[63:60] == 4'd0) || (csrWdata[63:60] == 4'd8) ||
                (csrWdata[63:60] == 4'd9);
    scauseRd = scauseQ;
    if (narrowMode) scauseRd[NARROW-1] = scauseQ[XLEN-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mstatusQ <= '0;  misaQ <= XLEN'(MISA_CAP);
      mtvecQ <= '0;  mepcQ <= '0;  mcauseQ <= '0;  mtvalQ <= '0;
      stvecQ <= '0;  sepcQ <= '0;  scauseQ <= '0;  stvalQ <= '0;
      satpQ  <= '0;  dpcQ  <= '0;
      pcQ    <= XLEN'(RESET_VEC);
      privQ  <= PRIV_M;
      flushQ <= 1'b0;
    end else begin
      flushQ <= wr && (strobes.sel == SEL_SATP);
      if (strobes.trapS) begin
        pcQ      <= stvecQ;
        scauseQ  <= trapCause;
        sepcQ    <= trapEpc & EVEN_MASK;
        stvalQ   <= trapTval;
        mstatusQ[ST_SPIE] <= mstatusQ[ST_SIE];
        mstatusQ[ST_SIE]  <= 1'b0;
        mstatusQ[ST_SPP]  <= (privQ != PRIV_U);
        privQ    <= PRIV_S;
      end else if (strobes.trapM) begin
        pcQ      <= (mtvecQ & EVEN_MASK) + vecOff;
        mcauseQ  <= trapCause;
        mepcQ    <= trapEpc & EVEN_MASK;
        mtvalQ   <= trapTval;
        mstatusQ[ST_MPIE] <= mstatusQ[ST_MIE];
        mstatusQ[ST_MIE]  <= 1'b0;
        mstatusQ[ST_MPP+1:ST_MPP] <= privQ;
        privQ    <= PRIV_M;
      end else if (wr) begin
        case (strobes.sel)
          SEL_MSTATUS: mstatusQ <= csrWdata & ST_WMASK;
          SEL_MISA:    misaQ    <= (misaNew & MISA_WMASK) | (misaQ & ~MISA_WMASK);
          SEL_MTVEC:   mtvecQ   <= csrWdata & ~XLEN'(2);
          SEL_MEPC:    mepcQ    <= csrWdata & EVEN_MASK;
          SEL_MCAUSE:  mcauseQ  <= csrWdata;
          SEL_MTVAL:   mtvalQ   <= csrWdata;
          SEL_STVEC:   stvecQ   <= csrWdata & ~XLEN'(3);
          SEL_SEPC:    sepcQ    <= csrWdata & EVEN_MASK;
          SEL_SCAUSE:  scauseQ  <= csrWdata;
          SEL_STVAL:   stvalQ   <= csrWdata;
          SEL_SATP:    if (satpLegal) satpQ <= csrWdata & SATP_KEEP;
          SEL_DPC:     dpcQ     <= csrWdata & EVEN_MASK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (strobes.sel)
      SEL_MSTATUS: csrRdata = mstatusQ;
      SEL_MISA:    csrRdata = misaQ;
      SEL_MTVEC:   csrRdata = mtvecQ;
      SEL_MEPC:    csrRdata = mepcQ;
      SEL_MCAUSE:  csrRdata = mcauseQ;
      SEL_MTVAL:   csrRdata = mtvalQ;
      SEL_STVEC:   csrRdata = stvecQ;
      SEL_SEPC:    csrRdata = sepcQ;
      SEL_SCAUSE:  csrRdata = scauseRd;
      SEL_STVAL:   csrRdata = stvalQ;
      SEL_SATP:    csrRdata = satpQ;
      SEL_DPC:     csrRdata = dpcQ;
      default:     csrRdata = '0;
    endcase
  end

  assign nextPc   = pcQ;
  assign privMode = privQ;
  assign tlbFlush = flushQ;

  assert_epc_even_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wr && (strobes.sel inside {SEL_MEPC, SEL_SEPC, SEL_DPC})) |=>
      (!mepcQ[0] && !sepcQ[0] && !dpcQ[0]));

  assert_trap_s_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.trapS |=> (privQ == PRIV_S) && !mstatusQ[ST_SIE] &&
      (mstatusQ[ST_SPIE] == $past(mstatusQ[ST_SIE])));

  assert_trap_m_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.trapM |=> (privQ == PRIV_M) && !mstatusQ[ST_MIE] &&
      (mstatusQ[ST_MPIE] == $past(mstatusQ[ST_MIE])));

  assert_misa_locked_bits_R6: assert property (@(posedge clk) disable iff (!rstN)
    (misaQ & ~MISA_WMASK) == (XLEN'(MISA_CAP) & ~MISA_WMASK));

  assert_flush_follows_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    tlbFlush |-> $past(wr && (strobes.sel == SEL_SATP)));

  assert_status_zero_bits_R12: assert property (@(posedge clk) disable iff (!rstN)
    (mstatusQ & ~ST_WMASK) == '0);

endmodule

// File: rtl/trap_csr_unit.sv
module trap_csr_unit
  import trap_csr_pkg::*;
#(
  parameter int          XLEN      = 64,
  parameter int          NARROW    = 32,
  parameter logic [63:0] RESET_VEC = 64'h0000_0000_8000_0000,
  parameter logic [63:0] MISA_CAP  = 64'h8000_0000_0014_112D
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [11:0]      csrAddr,
  input  logic [XLEN-1:0]  csrWdata,
  input  logic             csrWe,
  output logic [XLEN-1:0]  csrRdata,
  output logic             csrIllegal,
  input  logic             narrowMode,
  input  logic             trapValid,
  input  logic             trapToSuper,
  input  logic [XLEN-1:0]  trapCause,
  input  logic [XLEN-1:0]  trapEpc,
  input  logic [XLEN-1:0]  trapTval,
  output logic [XLEN-1:0]  nextPc,
  output logic [1:0]       privMode,
  output logic             tlbFlush
);

  ctrlStrobes_t strobes;

  trap_csr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrWe(csrWe),
    .trapValid(trapValid), .trapToSuper(trapToSuper),
    .strobes(strobes), .csrIllegal(csrIllegal)
  );

  trap_csr_dpath #(
    .XLEN(XLEN), .NARROW(NARROW), .RESET_VEC(RESET_VEC), .MISA_CAP(MISA_CAP)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .csrWdata(csrWdata),
    .narrowMode(narrowMode), .trapCause(trapCause), .trapEpc(trapEpc),
    .trapTval(trapTval), .csrRdata(csrRdata), .nextPc(nextPc),
    .privMode(privMode), .tlbFlush(tlbFlush)
  );

endmodule

// File: tb/trap_csr_unit_test.sv
module trap_csr_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] RVEC = 64'h0000_0000_8000_0000;
  localparam logic [63:0] CAP  = 64'h8000_0000_0014_112D;
  localparam int K_RD = 0, K_PC = 1, K_PRIV = 2, K_ILL = 3, K_FLUSH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] csrAddr = 12'h0;
  logic [63:0] csrWdata = '0;
  logic        csrWe = 1'b0;
  logic [63:0] csrRdata;
  logic        csrIllegal;
  logic        narrowMode = 1'b0;
  logic        trapValid = 1'b0;
  logic        trapToSuper = 1'b0;
  logic [63:0] trapCause = '0, trapEpc = '0, trapTval = '0;
  logic [63:0] nextPc;
  logic [1:0]  privMode;
  logic        tlbFlush;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  trap_csr_unit uut (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrWdata(csrWdata), .csrWe(csrWe),
    .csrRdata(csrRdata), .csrIllegal(csrIllegal), .narrowMode(narrowMode),
    .trapValid(trapValid), .trapToSuper(trapToSuper), .trapCause(trapCause),
    .trapEpc(trapEpc), .trapTval(trapTval), .nextPc(nextPc),
    .privMode(privMode), .tlbFlush(tlbFlush)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: compares each queued item at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it = sb.pop_front();
      case (it.kind)
        K_RD:    act = csrRdata;
        K_PC:    act = nextPc;
        K_PRIV:  act = {62'b0, privMode};
        K_ILL:   act = {63'b0, csrIllegal};
        default: act = {63'b0, tlbFlush};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expectVal(input int kind, input logic [11:0] addr,
                           input logic [63:0] exp, input string tag);
    csrAddr = addr;
    sb.push_back('{kind, exp, tag});
    @(posedge clk); #1;
  endtask

  task automatic expectNow(input int kind, input logic [63:0] exp, input string tag);
    sb.push_back('{kind, exp, tag});
    @(posedge clk); #1;
  endtask

  task automatic writeCsr(input logic [11:0] addr, input logic [63:0] data);
    csrAddr = addr; csrWdata = data; csrWe = 1'b1;
    @(posedge clk); #1;
    csrWe = 1'b0;
  endtask

  task automatic takeTrap(input bit toS, input logic [63:0] cause,
                          input logic [63:0] epc, input logic [63:0] tval);
    trapToSuper = toS; trapCause = cause; trapEpc = epc; trapTval = tval;
    trapValid = 1'b1;
    @(posedge clk); #1;
    trapValid = 1'b0; csrWe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    expectVal(K_PRIV, 12'h300, 64'd3, "R1 priv");
    expectVal(K_PC,   12'h300, RVEC, "R1 pc");
    expectVal(K_RD,   12'h301, CAP, "R1 misa");
    expectVal(K_RD,   12'h341, 64'd0, "R1 mepc");
    expectVal(K_RD,   12'h300, 64'd0, "R1 status");

    // R2 return address alignment
    writeCsr(12'h341, 64'h1235);
    writeCsr(12'h141, 64'hFFFF);
    writeCsr(12'h7B1, 64'h11);
    expectVal(K_RD, 12'h341, 64'h1234, "R2 mepc");
    expectVal(K_RD, 12'h141, 64'hFFFE, "R2 sepc");
    expectVal(K_RD, 12'h7B1, 64'h10, "R2 dpc");

    // R3 trap base legalization
    writeCsr(12'h305, 64'h1003);
    writeCsr(12'h105, 64'h4007);
    expectVal(K_RD, 12'h305, 64'h1001, "R3 mtvec");
    expectVal(K_RD, 12'h105, 64'h4004, "R3 stvec");

    // R6 capability word
    writeCsr(12'h301, 64'h0);
    expectVal(K_RD, 12'h301, 64'h8000_0000_0014_0100, "R6 clear writable");
    writeCsr(12'h301, 64'h1008);
    expectVal(K_RD, 12'h301, 64'h8000_0000_0014_1100, "R6 F clear drops D");
    writeCsr(12'h301, '1);
    expectVal(K_RD, 12'h301, CAP, "R6 all ones");

    // R7 / R8 translation root and flush
    writeCsr(12'h180, 64'h8000_1234_5678_9ABC);
    expectNow(K_FLUSH, 64'd1, "R8 flush legal write");
    expectVal(K_RD, 12'h180, 64'h8000_0234_5678_9ABC, "R7 legal mode");
    expectNow(K_FLUSH, 64'd0, "R8 flush single cycle");
    writeCsr(12'h180, 64'h5000_0000_0000_0001);
    expectNow(K_FLUSH, 64'd1, "R8 flush illegal write");
    expectVal(K_RD, 12'h180, 64'h8000_0234_5678_9ABC, "R7 illegal mode kept");
    writeCsr(12'h180, 64'h7);
    expectVal(K_RD, 12'h180, 64'h7, "R7 mode off");

    // R12 status mask
    writeCsr(12'h300, '1);
    expectVal(K_RD, 12'h300, 64'h19AA, "R12 status mask");
    writeCsr(12'h300, 64'h8);

    // R5 machine trap, exception: no offset
    takeTrap(1'b0, 64'd2, 64'h2000, 64'h55);
    expectVal(K_PC,   12'h341, 64'h1000, "R5 pc exception");
    expectVal(K_RD,   12'h341, 64'h2000, "R5 mepc");
    expectVal(K_RD,   12'h342, 64'd2, "R5 mcause");
    expectVal(K_RD,   12'h343, 64'h55, "R5 mtval");
    expectVal(K_RD,   12'h300, 64'h1880, "R5 status");
    expectVal(K_PRIV, 12'h300, 64'd3, "R5 priv");

    // R5 machine trap, interrupt: vectored offset 4*7
    takeTrap(1'b0, 64'h8000_0000_0000_0007, 64'h2101, 64'h0);
    expectVal(K_PC, 12'h341, 64'h101C, "R5 pc vectored");
    expectVal(K_RD, 12'h341, 64'h2100, "R5 mepc even");
    expectVal(K_RD, 12'h300, 64'h1800, "R5 status second");

    // R4 supervisor trap
    writeCsr(12'h300, 64'h2);
    takeTrap(1'b1, 64'd13, 64'h3001, 64'h99);
    expectVal(K_PC,   12'h141, 64'h4004, "R4 pc");
    expectVal(K_RD,   12'h141, 64'h3000, "R4 sepc");
    expectVal(K_RD,   12'h142, 64'd13, "R4 scause");
    expectVal(K_RD,   12'h143, 64'h99, "R4 stval");
    expectVal(K_RD,   12'h300, 64'h120, "R4 status");
    expectVal(K_PRIV, 12'h300, 64'd1, "R4 priv");

    // R9 narrow read of supervisor cause
    takeTrap(1'b1, 64'h8000_0000_0000_0005, 64'h10, 64'h0);
    expectVal(K_RD, 12'h300, 64'h100, "R4 status from S");
    narrowMode = 1'b1;
    expectVal(K_RD, 12'h142, 64'h8000_0000_8000_0005, "R9 narrow scause");
    narrowMode = 1'b0;
    expectVal(K_RD, 12'h142, 64'h8000_0000_0000_0005, "R9 wide scause");

    // R10 unimplemented address
    expectVal(K_RD,  12'h7C0, 64'd0, "R10 read zero");
    expectVal(K_ILL, 12'h7C0, 64'd1, "R10 flag");
    writeCsr(12'h7C0, 64'hDEAD);
    expectVal(K_RD,  12'h7C0, 64'd0, "R10 still zero");
    expectVal(K_RD,  12'h341, 64'h2100, "R10 mepc untouched");
    expectVal(K_ILL, 12'h341, 64'd0, "R10 flag low");

    // R11 collisions
    csrAddr = 12'h341; csrWdata = 64'h7777; csrWe = 1'b1;
    takeTrap(1'b0, 64'd3, 64'h6000, 64'h0);
    expectVal(K_RD,   12'h341, 64'h6000, "R11 mepc from trap");
    expectVal(K_PRIV, 12'h341, 64'd3, "R11 trap taken");
    csrAddr = 12'h180; csrWdata = 64'h8000_0000_0000_00FF; csrWe = 1'b1;
    takeTrap(1'b0, 64'd3, 64'h6100, 64'h0);
    expectNow(K_FLUSH, 64'd0, "R11 no flush");
    expectVal(K_RD, 12'h180, 64'h7, "R11 satp kept");

    @(posedge clk); #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule